// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block produces two divided bank clocks, A and C, from a single fast clock and a sync output marking the point where their rising edges line up. The two clocks may run at ratios that are not integer multiples of each other, for example 3:2 or 4:3. The sync output is active low. It drops for exactly one period of the faster bank clock just before the next common rising edge, and it returns high on the fast-clock cycle in which both bank clocks rise together. Logic that moves data between the two bank domains can use this mark to find the aligned edge.

The block does not look for edges. It predicts them. A phase counter runs over the least common multiple (LCM) of the two divide ratios, counted in fast-clock cycles. It is cleared together with the bank dividers, so phase zero is always a coincident edge. The divide selects are captured while reset is asserted. A run enable from the serial stop register can hold the sync output low without disturbing the bank clocks or the phase schedule.

Top module: `coinc_sync_gen`

## Requirements
- R1: `sel_a` chooses the bank A ratio: 0 gives 4, 1 gives 6, 2 gives 8 and 3 gives 12 fast cycles. In phase p after reset, `bank_a` is high when (p mod ratio) is less than ratio/2, and low otherwise.
- R2: `sel_c` chooses the bank C ratio: 0 gives 2, 1 gives 4, 2 gives 6 and 3 gives 8 fast cycles. `bank_c` follows the same half-high rule as `bank_a`.
- R3: The select inputs are captured only on clock edges where `rst` is high. Changing them while `rst` is low has no effect on any output.
- R4: While `rst` is high, `bank_a` and `bank_c` are low and `sync_n` is high. Phase 0 is the first clock edge after `rst` falls, and on it both bank clocks rise.
- R5: Let L be the LCM of the two ratios and m the smaller ratio. When the ratios differ and `sync_run` is high, `sync_n` is low for phases (p mod L) from L-m to L-1. That is m fast cycles immediately before each coincident rising edge.
- R6: When the ratios differ, `sync_n` is high at phase 0 of each L-cycle period, which is the coincident edge, and at every other phase outside the window of R5, unless the output is stopped.
- R7: When both ratios are equal, every bank period ends in a coincident edge, so `sync_n` stays low while running.
- R8: When `sync_run` is sampled low on a clock edge, `sync_n` is low after that edge. When `sync_run` is high again, `sync_n` resumes the schedule of R5 and R6 at the current phase.
- R9: Stopping the sync output does not pause or shift the bank clocks or the phase count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset; also captures the selects |
| sel_a | input | 2 | Bank A divide select |
| sel_c | input | 2 | Bank C divide select |
| sync_run | input | 1 | Sync output enable from the serial stop register |
| bank_a | output | 1 | Divided bank A clock |
| bank_c | output | 1 | Divided bank C clock |
| sync_n | output | 1 | Active-low coincidence warning |

## Verification
A phase counter that has slipped against the bank dividers shows within one LCM period. The low window then overlaps a rising edge of only one bank clock, or it misses the common edge. The reference model compares all three outputs on every fast cycle, so such a slip is caught within one LCM period, at most 24 cycles. A wrong ratio decode or a select that is captured outside reset shows within one bank period as a change in the high/low widths of that bank clock. A stop that leaks into the counters shows as shifted bank clocks on the first cycle after `sync_run` returns high.

// File: rtl/csync_pkg.sv
package csync_pkg;

  localparam int SEL_W = 2;
  localparam int CNT_W = 5;

  // bank A ratio decode (R1)
  function automatic int a_ratio(input logic [SEL_W-1:0] s);
    case (s)
      2'd0:    return 4;
      2'd1:    return 6;
      2'd2:    return 8;
      default: return 12;
    endcase
  endfunction

  // bank C ratio decode (R2)
  function automatic int c_ratio(input logic [SEL_W-1:0] s);
    case (s)
      2'd0:    return 2;
      2'd1:    return 4;
      2'd2:    return 6;
      default: return 8;
    endcase
  endfunction

  // smallest multiple of a that b divides
  function automatic int ratio_lcm(input int a, input int b);
    int r;
    r = a * b;
    for (int i = 1; i <= 16; i++) begin
      if (((a * i) % b) == 0 && (a * i) < r) r = a * i;
    end
    return r;
  endfunction

endpackage

// File: rtl/ratio_latch.sv
module ratio_latch
  import csync_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] sel_a,
  input  logic [SW-1:0] sel_c,
  output logic [CW-1:0] na,
  output logic [CW-1:0] nc,
  output logic [CW-1:0] nl,
  output logic [CW-1:0] nm
);

  int ra, rc;

  always_comb begin
    ra = a_ratio(sel_a);
    rc = c_ratio(sel_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      na <= CW'(ra);
      nc <= CW'(rc);
      nl <= CW'(ratio_lcm(ra, rc));
      nm <= CW'((ra < rc) ? ra : rc);
    end
  end

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(na) && $stable(nc) && $stable(nl))); // R3

endmodule

// File: rtl/bank_divider.sv
module bank_divider
  import csync_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] ratio,
  output logic          q
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      q   <= 1'b0;
    end else begin
      q   <= (cnt < (ratio >> 1));
      cnt <= (cnt == ratio - 1'b1) ? '0 : cnt + 1'b1;
    end
  end

  AST_EDGE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    $rose(q) |-> ($past(cnt) == '0)); // R1

endmodule

// File: rtl/sync_window.sv
module sync_window
  import csync_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] width,
  input  logic          run,
  output logic          sync_n
);

  logic [CW-1:0] phase;
  logic          win;

  always_comb win = (phase >= period - width);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      sync_n <= 1'b1;
    end else begin
      sync_n <= run & ~win;
      phase  <= (phase == period - 1'b1) ? '0 : phase + 1'b1;
    end
  end

  AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sync_n); // R8

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (phase == '0) |-> ($past(phase) == period - 1'b1) || $past(rst)); // R9

endmodule

// File: rtl/coinc_sync_gen.sv
module coinc_sync_gen
  import csync_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] sel_a,
  input  logic [SW-1:0] sel_c,
  input  logic          sync_run,
  output logic          bank_a,
  output logic          bank_c,
  output logic          sync_n
);

  localparam int NBANK = 2;

  logic [CW-1:0] na, nc, nl, nm;
  logic [CW-1:0] ratio_arr [NBANK];
  logic [NBANK-1:0] bank_q;

  ratio_latch #(.SW(SW), .CW(CW)) u_latch (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_c(sel_c),
    .na(na), .nc(nc), .nl(nl), .nm(nm)
  );

  always_comb begin
    ratio_arr[0] = na;
    ratio_arr[1] = nc;
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    bank_divider #(.CW(CW)) u_div (
      .clk(clk), .rst(rst), .ratio(ratio_arr[g]), .q(bank_q[g])
    );
  end

  sync_window #(.CW(CW)) u_win (
    .clk(clk), .rst(rst), .period(nl), .width(nm),
    .run(sync_run), .sync_n(sync_n)
  );

  assign bank_a = bank_q[0];
  assign bank_c = bank_q[1];

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (sync_n && !bank_a && !bank_c)); // R4

  AST_COINCIDE_HIGH: assert property (@(posedge clk) disable iff (rst)
    ($rose(bank_a) && $rose(bank_c) && $past(sync_run) && (na != nc))
      |-> sync_n); // R6

  AST_EQUAL_LOW: assert property (@(posedge clk) disable iff (rst)
    ((na == nc) && !$past(rst)) |-> !sync_n); // R7

endmodule

// File: tb/test_coinc_sync_gen.sv
`timescale 1ns/1ps
module test_coinc_sync_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel_a = 2'd0;
  logic [1:0] sel_c = 2'd0;
  logic       sync_run = 1'b1;
  logic       bank_a, bank_c, sync_n;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  coinc_sync_gen i_coinc_sync_gen (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_c(sel_c),
    .sync_run(sync_run), .bank_a(bank_a), .bank_c(bank_c), .sync_n(sync_n)
  );

  // reference model
  int  m_na, m_nc, m_l, m_m, k;
  bit  e_a, e_c, e_s, armed, in_rst, stopped, sel_moved;

  function automatic int tb_ra(input logic [1:0] s);
    int t[4] = '{4, 6, 8, 12};
    return t[s];
  endfunction
  function automatic int tb_rc(input logic [1:0] s);
    return 2 * (int'(s) + 1);
  endfunction
  function automatic int tb_gcd(input int a, input int b);
    int x = a, y = b, t;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return x;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_na = tb_ra(sel_a);
      m_nc = tb_rc(sel_c);
      m_l  = m_na * m_nc / tb_gcd(m_na, m_nc);
      m_m  = (m_na < m_nc) ? m_na : m_nc;
      k = 0; e_a = 0; e_c = 0; e_s = 1;
      armed = 1; in_rst = 1; stopped = 0; sel_moved = 0;
    end else begin
      e_a = (k % m_na) < (m_na / 2);
      e_c = (k % m_nc) < (m_nc / 2);
      e_s = sync_run && ((k % m_l) < (m_l - m_m));
      stopped   = !sync_run;
      sel_moved = (tb_ra(sel_a) != m_na) || (tb_rc(sel_c) != m_nc);
      in_rst = 0;
      k++;
    end
  end

  task automatic check(input bit act, input bit exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      string ta, tc, ts;
      if (in_rst) begin
        ta = "R4"; tc = "R4"; ts = "R4";
      end else begin
        ta = stopped ? "R9" : (sel_moved ? "R3" : "R1");
        tc = stopped ? "R9" : (sel_moved ? "R3" : "R2");
        if (stopped)             ts = "R8";
        else if (m_na == m_nc)   ts = "R7";
        else if (!e_s)           ts = "R5";
        else                     ts = "R6";
      end
      check(bank_a, e_a, {ta, " bank_a"});
      check(bank_c, e_c, {tc, " bank_c"});
      check(sync_n, e_s, {ts, " sync_n"});
    end
  end

  task automatic run_case(input logic [1:0] sa, input logic [1:0] sc);
    int len;
    len = 2 * tb_ra(sa) * tb_rc(sc) / tb_gcd(tb_ra(sa), tb_rc(sc)) + 6;
    @(negedge clk);
    rst = 1'b1; sel_a = sa; sel_c = sc; sync_run = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (len) @(negedge clk);
    // stop the sync output for a while (R8, R9)
    sync_run = 1'b0;
    repeat (7) @(negedge clk);
    sync_run = 1'b1;
    // move selects outside reset: must be ignored (R3)
    sel_a = ~sa; sel_c = sa ^ sc ^ 2'd1;
    repeat (len) @(negedge clk);
  endtask

  initial begin
    run_case(2'd0, 2'd1);  // 4:4   R7
    run_case(2'd2, 2'd1);  // 8:4
    run_case(2'd1, 2'd0);  // 6:2
    run_case(2'd0, 2'd2);  // 4:6
    run_case(2'd2, 2'd0);  // 8:2
    run_case(2'd1, 2'd3);  // 6:8
    run_case(2'd3, 2'd0);  // 12:2
    run_case(2'd3, 2'd3);  // 12:8
    run_case(2'd2, 2'd3);  // 8:8   R7
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule